// File: doc/BRIEF.md
# Four-Lane Redundancy Port Switch

This block joins three four-lane ports. Toward the shared port C it works as a per-lane two-way selector: every lane of C is fed from the matching lane of port A or of port B, as that lane's own select bit decides. Away from port C it works as a per-lane splitter. Each lane of C goes to A, to B, or to both when bicast is on. A lane of A or B that is not fed is marked idle. Each lane carries a parameterised word, and the lanes are independent.

Each port has a loopback enable. Loopback returns the port's own input to its output and takes priority over the lane selects and bicast for that port only. A reverse control swaps the two bus roles of port C. The bus that normally receives becomes the driven one, and the other bus becomes the input. Each bus has its own output enable, so a pad ring can tri-state the bus that is not driven.

All data and control inputs pass through one register stage. Every output lane therefore follows its inputs by exactly one clock, with no skew between lanes.

Top module: `lsw_top`

## Requirements
- R1: While reset is asserted, and after its release until the first clock edge, every lane of A, B and C reports idle (flag 1, word all ones) and both port C output enables are 0.
- R2: Every output reflects the data and control inputs sampled at the preceding rising clock edge: one cycle of latency, the same for all lanes.
- R3: Port C lane i carries port C's own input lane i when loop_c is 1. Otherwise it carries B lane i when lane_sel[i] is 1, and A lane i when lane_sel[i] is 0.
- R4: Port A lane i carries a_in lane i when loop_a is 1. Otherwise it carries port C's input lane i when lane_sel[i] is 0 or bicast_en is 1. In every other case it is idle.
- R5: Port B lane i carries b_in lane i when loop_b is 1. Otherwise it carries port C's input lane i when lane_sel[i] is 1 or bicast_en is 1. In every other case it is idle.
- R6: An idle lane outputs the all-ones word and raises its idle flag. A lane that carries data has its flag at 0.
- R7: A port's loopback enable overrides lane_sel and bicast_en for that port only. The other ports keep their normal routing.
- R8: With c_reverse at 0, port C reads cx_in and drives cy_out (cy_oe=1, cx_oe=0). With c_reverse at 1, it reads cy_in and drives cx_out (cx_oe=1, cy_oe=0). Lane i of each bus occupies bits [i*W +: W].
- R9: Each lane's routing depends only on its own select bit and the port-wide controls. Mixed select patterns route every lane independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_sel | input | LANES | Per-lane choice, 0 = A, 1 = B |
| bicast_en | input | 1 | Send port C input to both A and B |
| loop_a | input | 1 | Loopback for port A |
| loop_b | input | 1 | Loopback for port B |
| loop_c | input | 1 | Loopback for port C |
| c_reverse | input | 1 | Swap the port C bus roles |
| a_in | input | LANES*W | Port A receive lanes |
| b_in | input | LANES*W | Port B receive lanes |
| a_out | output | LANES*W | Port A transmit lanes |
| a_idle | output | LANES | Port A lane idle flags |
| b_out | output | LANES*W | Port B transmit lanes |
| b_idle | output | LANES | Port B lane idle flags |
| c_idle | output | LANES | Port C lane idle flags |
| cx_in | input | LANES*W | Port C bus X input side (receive by default) |
| cx_out | output | LANES*W | Port C bus X output side |
| cx_oe | output | 1 | Bus X drive enable |
| cy_in | input | LANES*W | Port C bus Y input side |
| cy_out | output | LANES*W | Port C bus Y output side (transmit by default) |
| cy_oe | output | 1 | Bus Y drive enable |

## Verification
A wrong routing choice inside one lane shows up one clock later as a wrong word or idle flag on that lane alone. The scoreboard compares every lane of every port in every cycle, so the fault is reported in the cycle it appears. A stale or swapped reverse setting shows up at once as the wrong output enable or the wrong bus carrying port C data. A skipped or doubled register stage shows up as a one-cycle slip against the queued expectations, because the stimulus changes on every cycle of the randomised run.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2,
    SRC_C    = 2'd3
  } lsw_src_e;

  // source for an A-side lane: loopback first, then splitter
  function automatic lsw_src_e pick_a(input logic lb, input logic sel, input logic bc);
    if (lb)             return SRC_A;
    else if (!sel || bc) return SRC_C;
    else                return SRC_IDLE;
  endfunction

  function automatic lsw_src_e pick_b(input logic lb, input logic sel, input logic bc);
    if (lb)            return SRC_B;
    else if (sel || bc) return SRC_C;
    else               return SRC_IDLE;
  endfunction

  // source for a C-side lane: loopback first, then selector
  function automatic lsw_src_e pick_c(input logic lb, input logic sel);
    if (lb)       return SRC_C;
    else if (sel) return SRC_B;
    else          return SRC_A;
  endfunction

endpackage

// File: rtl/lsw_stage.sv
module lsw_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_nxt;
  logic             ld;

  always_comb begin
    ld    = 1'b1;
    q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= q_nxt;
  end

endmodule

// File: rtl/lsw_lane_route.sv
module lsw_lane_route
  import lsw_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_w,
  input  logic [W-1:0] b_w,
  input  logic [W-1:0] c_w,
  input  logic         sel,
  input  logic         bicast,
  input  logic         lb_a,
  input  logic         lb_b,
  input  logic         lb_c,
  input  logic         valid,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] c_o,
  output logic         a_idle,
  output logic         b_idle,
  output logic         c_idle
);

  lsw_src_e src_a, src_b, src_c;

  function automatic logic [W-1:0] steer(input lsw_src_e s, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic [W-1:0] c);
    case (s)
      SRC_A:   return a;
      SRC_B:   return b;
      SRC_C:   return c;
      default: return '1;
    endcase
  endfunction

  always_comb begin
    src_a  = valid ? pick_a(lb_a, sel, bicast) : SRC_IDLE;
    src_b  = valid ? pick_b(lb_b, sel, bicast) : SRC_IDLE;
    src_c  = valid ? pick_c(lb_c, sel)         : SRC_IDLE;
    a_o    = steer(src_a, a_w, b_w, c_w);
    b_o    = steer(src_b, a_w, b_w, c_w);
    c_o    = steer(src_c, a_w, b_w, c_w);
    a_idle = (src_a == SRC_IDLE);
    b_idle = (src_b == SRC_IDLE);
    c_idle = (src_c == SRC_IDLE);
  end

endmodule

// File: rtl/lsw_portc_io.sv
module lsw_portc_io #(
  parameter int LW = 32
) (
  input  logic          rev,
  input  logic          valid,
  input  logic [LW-1:0] x_q,
  input  logic [LW-1:0] y_q,
  input  logic [LW-1:0] c_tx,
  output logic [LW-1:0] c_rx,
  output logic [LW-1:0] x_out,
  output logic [LW-1:0] y_out,
  output logic          x_oe,
  output logic          y_oe
);

  always_comb begin
    c_rx  = rev ? y_q : x_q;
    x_oe  = valid &  rev;
    y_oe  = valid & ~rev;
    x_out = x_oe ? c_tx : '1;
    y_out = y_oe ? c_tx : '1;
  end

endmodule

// File: rtl/lsw_top.sv
module lsw_top #(
  parameter int LANES = 4,
  parameter int W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES-1:0]   lane_sel,
  input  logic               bicast_en,
  input  logic               loop_a,
  input  logic               loop_b,
  input  logic               loop_c,
  input  logic               c_reverse,
  input  logic [LANES*W-1:0] a_in,
  input  logic [LANES*W-1:0] b_in,
  output logic [LANES*W-1:0] a_out,
  output logic [LANES-1:0]   a_idle,
  output logic [LANES*W-1:0] b_out,
  output logic [LANES-1:0]   b_idle,
  output logic [LANES-1:0]   c_idle,
  input  logic [LANES*W-1:0] cx_in,
  output logic [LANES*W-1:0] cx_out,
  output logic               cx_oe,
  input  logic [LANES*W-1:0] cy_in,
  output logic [LANES*W-1:0] cy_out,
  output logic               cy_oe
);

  localparam int LW = LANES * W;
  localparam int CW = LANES + 5;
  localparam int DW = 4 * LW;

  logic [CW-1:0]    ctl_d, ctl_q;
  logic [DW-1:0]    dat_d, dat_q;
  logic [0:0]       vld_q;
  logic [LANES-1:0] sel_q;
  logic             bc_q, la_q, lb_q, lc_q, rev_q, valid_q;
  logic [LW-1:0]    a_q, b_q, x_q, y_q, c_rx, c_tx;

  assign ctl_d = {lane_sel, bicast_en, loop_a, loop_b, loop_c, c_reverse};
  assign dat_d = {a_in, b_in, cx_in, cy_in};

  lsw_stage #(.WIDTH(CW)) u_ctl (.clk(clk), .rst_n(rst_n), .d(ctl_d), .q(ctl_q));
  lsw_stage #(.WIDTH(DW)) u_dat (.clk(clk), .rst_n(rst_n), .d(dat_d), .q(dat_q));
  lsw_stage #(.WIDTH(1))  u_vld (.clk(clk), .rst_n(rst_n), .d(1'b1),  .q(vld_q));

  assign {sel_q, bc_q, la_q, lb_q, lc_q, rev_q} = ctl_q;
  assign {a_q, b_q, x_q, y_q} = dat_q;
  assign valid_q = vld_q[0];

  lsw_portc_io #(.LW(LW)) u_cio (
    .rev(rev_q), .valid(valid_q), .x_q(x_q), .y_q(y_q), .c_tx(c_tx),
    .c_rx(c_rx), .x_out(cx_out), .y_out(cy_out), .x_oe(cx_oe), .y_oe(cy_oe)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lsw_lane_route #(.W(W)) u_route (
      .a_w(a_q[i*W +: W]), .b_w(b_q[i*W +: W]), .c_w(c_rx[i*W +: W]),
      .sel(sel_q[i]), .bicast(bc_q), .lb_a(la_q), .lb_b(lb_q), .lb_c(lc_q),
      .valid(valid_q),
      .a_o(a_out[i*W +: W]), .b_o(b_out[i*W +: W]), .c_o(c_tx[i*W +: W]),
      .a_idle(a_idle[i]), .b_idle(b_idle[i]), .c_idle(c_idle[i])
    );

    a_r6_idle_ones_a: assert property (@(posedge clk) disable iff (!rst_n)
      a_idle[i] |-> (&a_out[i*W +: W]));
    a_r6_idle_ones_b: assert property (@(posedge clk) disable iff (!rst_n)
      b_idle[i] |-> (&b_out[i*W +: W]));
    a_r7_loop_a: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && $past(loop_a)) |-> (a_out[i*W +: W] == $past(a_in[i*W +: W]) && !a_idle[i]));
    a_r5_unicast_b_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && $past(!loop_b && !lane_sel[i] && !bicast_en)) |-> b_idle[i]);
    a_r3_c_from_a: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && $past(!loop_c && !lane_sel[i])) |-> (c_tx[i*W +: W] == $past(a_in[i*W +: W])));
  end

  a_r8_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $onehot({cx_oe, cy_oe}));
  a_r8_rev_drives_x: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && $past(c_reverse)) |-> (cx_oe && !cy_oe));

  // R1: reset holds every lane idle and both bus drivers off
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_idle: assert ((&a_idle) && (&b_idle) && (&c_idle) && !cx_oe && !cy_oe);
    end
  end

endmodule

// File: tb/lsw_top_tb.sv
`timescale 1ns/1ps
module lsw_top_tb;

  localparam int LANES = 4;
  localparam int W     = 8;
  localparam int LW    = LANES * W;

  typedef struct {
    logic [LW-1:0]    a, b, c;
    logic [LANES-1:0] ai, bi;
    logic             rv;
    string            note;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES-1:0] lane_sel = '0;
  logic bicast_en = 1'b0, loop_a = 1'b0, loop_b = 1'b0, loop_c = 1'b0, c_reverse = 1'b0;
  logic [LW-1:0] a_in = '0, b_in = '0, cx_in = '0, cy_in = '0;
  logic [LW-1:0] a_out, b_out, cx_out, cy_out;
  logic [LANES-1:0] a_idle, b_idle, c_idle;
  logic cx_oe, cy_oe;

  int checks = 0;
  int failures = 0;
  exp_t sb[$];

  always #10 clk = ~clk;

  lsw_top #(.LANES(LANES), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .lane_sel(lane_sel), .bicast_en(bicast_en),
    .loop_a(loop_a), .loop_b(loop_b), .loop_c(loop_c), .c_reverse(c_reverse),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_idle(a_idle),
    .b_out(b_out), .b_idle(b_idle), .c_idle(c_idle),
    .cx_in(cx_in), .cx_out(cx_out), .cx_oe(cx_oe),
    .cy_in(cy_in), .cy_out(cy_out), .cy_oe(cy_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // expected routing computed from R3..R6 and R8
  function automatic exp_t model(input string note);
    exp_t e;
    logic [W-1:0] cw;
    e.rv = c_reverse;
    e.note = note;
    for (int l = 0; l < LANES; l++) begin
      cw = c_reverse ? cy_in[l*W +: W] : cx_in[l*W +: W];
      if (loop_c)            e.c[l*W +: W] = cw;
      else if (lane_sel[l])  e.c[l*W +: W] = b_in[l*W +: W];
      else                   e.c[l*W +: W] = a_in[l*W +: W];
      e.ai[l] = 1'b0;
      if (loop_a)                          e.a[l*W +: W] = a_in[l*W +: W];
      else if (bicast_en || !lane_sel[l])  e.a[l*W +: W] = cw;
      else begin e.a[l*W +: W] = '1; e.ai[l] = 1'b1; end
      e.bi[l] = 1'b0;
      if (loop_b)                          e.b[l*W +: W] = b_in[l*W +: W];
      else if (bicast_en || lane_sel[l])   e.b[l*W +: W] = cw;
      else begin e.b[l*W +: W] = '1; e.bi[l] = 1'b1; end
    end
    return e;
  endfunction

  task automatic drive(input logic [LANES-1:0] s, input logic bc, input logic la,
                       input logic lb, input logic lc, input logic rv,
                       input logic [LW-1:0] a, input logic [LW-1:0] b,
                       input logic [LW-1:0] x, input logic [LW-1:0] y, input string note);
    exp_t e;
    @(negedge clk);
    lane_sel = s; bicast_en = bc; loop_a = la; loop_b = lb; loop_c = lc; c_reverse = rv;
    a_in = a; b_in = b; cx_in = x; cy_in = y;
    e = model(note);
    #1 sb.push_back(e);
  endtask

  // monitor: result of the previous cycle's stimulus (R2: one-cycle latency)
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      logic [LW-1:0] cbus;
      e = sb.pop_front();
      cbus = e.rv ? cx_out : cy_out;
      chk(a_out == e.a, "R4", {e.note, " a_out"}, a_out, e.a);
      chk(b_out == e.b, "R5", {e.note, " b_out"}, b_out, e.b);
      chk(cbus == e.c,  "R3", {e.note, " c bus"}, cbus, e.c);
      chk(a_idle == e.ai && b_idle == e.bi && c_idle == '0, "R6",
          {e.note, " idle flags"}, {a_idle, b_idle, c_idle}, {e.ai, e.bi, 4'h0});
      chk(cx_oe == e.rv && cy_oe == !e.rv, "R8", {e.note, " oe"},
          {cx_oe, cy_oe}, {e.rv, !e.rv});
    end
  end

  task automatic reset_check(input string when);
    chk(&a_idle && &b_idle && &c_idle, "R1", {when, " idle flags"},
        {a_idle, b_idle, c_idle}, '1);
    chk(&a_out && &b_out, "R1", {when, " idle words"}, a_out & b_out, '1);
    chk(!cx_oe && !cy_oe, "R1", {when, " oe"}, {cx_oe, cy_oe}, '0);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [LW-1:0] pa = 32'hA3A2A1A0, pb = 32'hB3B2B1B0, px = 32'hC3C2C1C0, py = 32'hD3D2D1D0;
    a_in = pa; b_in = pb; cx_in = px; cy_in = py; lane_sel = 4'hF; bicast_en = 1'b1;
    repeat (3) @(negedge clk);
    reset_check("R1 during reset");
    rst_n = 1'b1;
    #1 reset_check("R1 after release");
    lane_sel = '0; bicast_en = 1'b0;

    drive(4'h0, 0, 0, 0, 0, 0, pa, pb, px, py, "R4/R5 unicast all A");
    drive(4'hF, 0, 0, 0, 0, 0, pa, pb, px, py, "R5 unicast all B");
    drive(4'h5, 0, 0, 0, 0, 0, pa, pb, px, py, "R9 mixed 0101");
    drive(4'hA, 1, 0, 0, 0, 0, pa, pb, px, py, "R4/R5 bicast");
    drive(4'hF, 0, 1, 0, 0, 0, pa, pb, px, py, "R7 loop A");
    drive(4'h0, 1, 0, 1, 0, 0, pa, pb, px, py, "R7 loop B");
    drive(4'h6, 0, 0, 0, 1, 0, pa, pb, px, py, "R7 loop C");
    drive(4'h9, 1, 1, 1, 1, 0, pa, pb, px, py, "R7 all loops");
    drive(4'h3, 0, 0, 0, 0, 1, pa, pb, px, py, "R8 reversed");
    drive(4'hC, 1, 0, 0, 1, 1, pa, pb, px, py, "R8 reversed loop C");
    for (int k = 0; k < 200; k++) begin
      drive($urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, $urandom, $urandom, "R2 random stream");
    end
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule